// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves 8-bit words over one bidirectional data line and drives a shift clock on a second pin. The data line is modelled as an output value, an output enable and an input. The system clock is divided by 12 or by 4 to give the bit period. A control bit picks the divider. The divider is captured when a word starts, so a later change of that bit has no effect on the word in flight.

Firmware controls the port through two write strobes. A write to the data register starts a transmit. A receive starts whenever receive is enabled and the receive-done flag is clear. A done flag sets when the eighth bit has been moved. Only a software write to the control register clears a done flag. While the receive-done flag is set, no further reception starts.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, ctrl_o reads 0x00, rx_data_o reads 0x00, sclk_o and sdat_o are 1, and sdat_oe_o is 0.
- R2: The control byte has this layout: bits [7:6] are the mode, bit 5 is the speed select (1 = fast), bit 4 is receive enable, bit 1 is transmit-done and bit 0 is receive-done. Bits [3:2] always read 0. A control write loads every bit from ctrl_wdata_i.
- R3: A transfer starts only when the mode field is 00. A data write or an active receive enable under any other mode leaves the pins idle.
- R4: A bit period lasts 12 clocks when the speed select is 0 and 4 clocks when it is 1. The speed is captured at the start of the word. The shift clock is low for the first half of each bit period and high for the second half.
- R5: A transmit begins in the cycle after a data write taken while idle. sdat_oe_o is high for exactly 8 bit periods. The data goes out least significant bit first, and each bit is driven from the start of its period and held while the shift clock is high.
- R6: transmit-done sets at the clock edge that ends the eighth bit period. sdat_oe_o falls at that same edge.
- R7: A receive starts when the mode is 00, receive enable is 1, receive-done is 0 and the port is idle. A transmit start has priority. sdat_i is sampled at the clock edge where sclk_o rises, least significant bit first. rx_data_o is updated and receive-done sets at the edge that ends the eighth bit period.
- R8: While receive-done is 1, no receive starts and rx_data_o holds its value. After a control write clears the flag with receive enable still 1, a new receive starts one cycle later.
- R9: Clearing receive enable during a receive aborts it at the next edge. sclk_o returns high, receive-done stays 0 and rx_data_o is unchanged.
- R10: Neither done flag is ever cleared by hardware. If a hardware set and a software write land on the same edge, the flag ends up set.
- R11: A data write taken while a transfer is active is ignored.
- R12: Whenever no transfer is active, sclk_o and sdat_o are 1 and sdat_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write value |
| data_we_i | input | 1 | Data register write strobe, starts a transmit |
| data_wdata_i | input | DATA_W | Word to transmit |
| sdat_i | input | 1 | Data line as seen at the pin |
| ctrl_o | output | 8 | Control and flag register read value |
| rx_data_o | output | DATA_W | Last completed received word |
| sclk_o | output | 1 | Shift clock, idles high |
| sdat_o | output | 1 | Data line drive value, idles high |
| sdat_oe_o | output | 1 | Data line output enable, high while transmitting |

## Verification
If the phase counter or the captured divider goes wrong, the shift clock shows a wrong high or low width within one bit period. That is at most 12 clocks after the error. If the bit counter or shift register goes wrong, the word comes out wrong, or transmit-done appears at the wrong time, no later than the end of the word. If the sequencing state goes wrong, the pins toggle while idle, or a receive starts while receive-done is held. Either shows up in the very next cycle. The reference model is compared against every output on every clock, so each such fault is reported at the cycle where it first reaches a pin.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam logic [1:0] MODE_SHIFT = 2'b00;

  localparam int unsigned BIT_RX_DONE = 0;
  localparam int unsigned BIT_TX_DONE = 1;
  localparam int unsigned BIT_RX_EN   = 4;
  localparam int unsigned BIT_FAST    = 5;
  localparam int unsigned BIT_MODE_LO = 6;

  typedef struct packed {
    logic [1:0] mode;
    logic       fast;
    logic       rx_en;
    logic       tx_done;
    logic       rx_done;
  } ctrl_t;

  function automatic logic [7:0] ctrl_pack(ctrl_t c);
    logic [7:0] v;
    v = '0;
    v[BIT_MODE_LO +: 2] = c.mode;
    v[BIT_FAST]         = c.fast;
    v[BIT_RX_EN]        = c.rx_en;
    v[BIT_TX_DONE]      = c.tx_done;
    v[BIT_RX_DONE]      = c.rx_done;
    return v;
  endfunction

endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       set_tx_i,
  input  logic       set_rx_i,
  output ctrl_t      ctrl_o
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (we_i) begin
        ctrl_q.mode    <= wdata_i[BIT_MODE_LO +: 2];
        ctrl_q.fast    <= wdata_i[BIT_FAST];
        ctrl_q.rx_en   <= wdata_i[BIT_RX_EN];
        ctrl_q.tx_done <= wdata_i[BIT_TX_DONE];
        ctrl_q.rx_done <= wdata_i[BIT_RX_DONE];
      end
      // hardware set wins over a same-cycle software clear
      if (set_tx_i) ctrl_q.tx_done <= 1'b1;
      if (set_rx_i) ctrl_q.rx_done <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/ssp_timer.sv
module ssp_timer #(
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  input  logic busy_i,
  output logic rise_o,
  output logic end_o,
  output logic sclk_o
);

  localparam int unsigned MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int unsigned DW      = $clog2(MAX_DIV + 1);
  localparam logic [DW-1:0] SLOW_L = DW'(SLOW_DIV);
  localparam logic [DW-1:0] FAST_L = DW'(FAST_DIV);
  localparam logic [DW-1:0] ONE_L  = DW'(1);

  generate
    if (SLOW_DIV < 2 || FAST_DIV < 2 || (SLOW_DIV % 2) != 0 || (FAST_DIV % 2) != 0) begin : g_bad_div
      $error("ssp_timer: dividers must be even and at least 2");
    end
  endgenerate

  logic [DW-1:0] div_q;
  logic [DW-1:0] phase_q;
  logic [DW-1:0] half;

  assign half   = div_q >> 1;
  assign rise_o = busy_i && (phase_q == half - ONE_L);
  assign end_o  = busy_i && (phase_q == div_q - ONE_L);
  assign sclk_o = !busy_i || (phase_q >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= SLOW_L;
      phase_q <= '0;
    end else if (start_i) begin
      div_q   <= fast_i ? FAST_L : SLOW_L;
      phase_q <= '0;
    end else if (busy_i) begin
      phase_q <= end_o ? '0 : phase_q + ONE_L;
    end else begin
      phase_q <= '0;
    end
  end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_tx_i,
  input  logic              start_rx_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              abort_i,
  input  logic              rise_i,
  input  logic              end_i,
  input  logic              sdat_i,
  output logic              busy_o,
  output logic              tx_o,
  output logic              sdat_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_data_o
);

  localparam int unsigned CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST_L = CW'(DATA_W - 1);

  logic              busy_q;
  logic              tx_q;
  logic [CW-1:0]     bit_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              last;

  assign last      = (bit_q == LAST_L);
  assign tx_done_o = busy_q && tx_q && end_i && last;
  assign rx_done_o = busy_q && !tx_q && !abort_i && end_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tx_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (abort_i) begin
        busy_q <= 1'b0;
      end else begin
        if (rise_i && !tx_q) sh_q <= {sdat_i, sh_q[DATA_W-1:1]};
        if (end_i) begin
          if (last) begin
            busy_q <= 1'b0;
            if (!tx_q) rx_q <= sh_q;
          end else begin
            bit_q <= bit_q + CW'(1);
          end
          if (tx_q) sh_q <= {1'b1, sh_q[DATA_W-1:1]};
        end
      end
    end else if (start_tx_i) begin
      busy_q <= 1'b1;
      tx_q   <= 1'b1;
      bit_q  <= '0;
      sh_q   <= tx_word_i;
    end else if (start_rx_i) begin
      busy_q <= 1'b1;
      tx_q   <= 1'b0;
      bit_q  <= '0;
    end
  end

  assign busy_o    = busy_q;
  assign tx_o      = tx_q;
  assign sdat_o    = (busy_q && tx_q) ? sh_q[0] : 1'b1;
  assign rx_data_o = rx_q;

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLOW_DIV = 12,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  input  logic              sdat_i,
  output logic [7:0]        ctrl_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              sdat_oe_o
);

  ctrl_t ctrl;
  logic  busy, is_tx, mode_ok;
  logic  start_tx, start_rx, abort;
  logic  rise, bit_end;
  logic  set_tx, set_rx;

  assign mode_ok  = (ctrl.mode == MODE_SHIFT);
  assign start_tx = !busy && mode_ok && data_we_i;
  assign start_rx = !busy && mode_ok && !data_we_i && ctrl.rx_en && !ctrl.rx_done;
  assign abort    = busy && !is_tx && !ctrl.rx_en;

  ssp_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .set_tx_i (set_tx),
    .set_rx_i (set_rx),
    .ctrl_o   (ctrl)
  );

  ssp_timer #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_tx || start_rx),
    .fast_i  (ctrl.fast),
    .busy_i  (busy),
    .rise_o  (rise),
    .end_o   (bit_end),
    .sclk_o  (sclk_o)
  );

  ssp_shifter #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_tx_i (start_tx),
    .start_rx_i (start_rx),
    .tx_word_i  (data_wdata_i),
    .abort_i    (abort),
    .rise_i     (rise),
    .end_i      (bit_end),
    .sdat_i     (sdat_i),
    .busy_o     (busy),
    .tx_o       (is_tx),
    .sdat_o     (sdat_o),
    .tx_done_o  (set_tx),
    .rx_done_o  (set_rx),
    .rx_data_o  (rx_data_o)
  );

  assign sdat_oe_o = busy && is_tx;
  assign ctrl_o    = ctrl_pack(ctrl);

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [7:0]        ctrl_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              sclk_o,
  input logic              sdat_o,
  input logic              sdat_oe_o,
  input logic              busy_i
);

  assert_txdone_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_o[1]) && !$past(ctrl_we_i)) |-> ($past(sdat_oe_o) && !sdat_oe_o));

  assert_rxdone_sw_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[0]) |-> $past(ctrl_we_i));

  assert_txdone_sw_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o[1]) |-> $past(ctrl_we_i));

  assert_rx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[0] && $past(ctrl_o[0])) |-> $stable(rx_data_o));

  assert_idle_pins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sclk_o && sdat_o && !sdat_oe_o));

  assert_tx_hold_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdat_oe_o && sclk_o) |-> $stable(sdat_o));

endmodule

bind sync_shift_port ssp_checker #(.DATA_W(DATA_W)) u_ssp_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_we_i (ctrl_we_i),
  .ctrl_o    (ctrl_o),
  .rx_data_o (rx_data_o),
  .sclk_o    (sclk_o),
  .sdat_o    (sdat_o),
  .sdat_oe_o (sdat_oe_o),
  .busy_i    (busy)
);

// File: tb/sync_shift_port_bench.sv
module sync_shift_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic       sdat_in = 1'b1;
  logic [7:0] ctrl_rd;
  logic [7:0] rx_data;
  logic       sclk, sdat, sdat_oe;

  sync_shift_port u_sync_shift_port (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .data_we_i(data_we), .data_wdata_i(data_wdata), .sdat_i(sdat_in),
    .ctrl_o(ctrl_rd), .rx_data_o(rx_data), .sclk_o(sclk), .sdat_o(sdat), .sdat_oe_o(sdat_oe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int         m_busy, m_tx, m_c, m_div;
  logic [1:0] m_mode;
  logic       m_fast, m_rxen, m_txd, m_rxd;
  logic [7:0] m_txw, m_rxw, m_rxdata;
  logic [7:0] slave_word = 8'h00;
  int         st_tx, st_rx, set_t, set_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_tx = 0; m_c = 0; m_div = 12;
      m_mode = 2'b00; m_fast = 0; m_rxen = 0; m_txd = 0; m_rxd = 0;
      m_txw = 0; m_rxw = 0; m_rxdata = 0;
    end else begin
      st_tx = (!m_busy && data_we && m_mode == 2'b00) ? 1 : 0;
      st_rx = (!m_busy && !st_tx && m_mode == 2'b00 && m_rxen && !m_rxd) ? 1 : 0;
      set_t = 0; set_r = 0;
      if (m_busy != 0) begin
        if (m_tx == 0 && !m_rxen) m_busy = 0;
        else begin
          if (m_tx == 0 && (m_c % m_div) == m_div / 2 - 1) m_rxw[m_c / m_div] = sdat_in;
          if (m_c == 8 * m_div - 1) begin
            m_busy = 0;
            if (m_tx != 0) set_t = 1;
            else begin set_r = 1; m_rxdata = m_rxw; end
          end else m_c++;
        end
      end else if (st_tx != 0) begin
        m_busy = 1; m_tx = 1; m_c = 0; m_div = m_fast ? 4 : 12; m_txw = data_wdata;
      end else if (st_rx != 0) begin
        m_busy = 1; m_tx = 0; m_c = 0; m_div = m_fast ? 4 : 12;
      end
      if (ctrl_we) begin
        m_mode = ctrl_wdata[7:6]; m_fast = ctrl_wdata[5]; m_rxen = ctrl_wdata[4];
        m_txd = ctrl_wdata[1]; m_rxd = ctrl_wdata[0];
      end
      if (set_t != 0) m_txd = 1;
      if (set_r != 0) m_rxd = 1;
    end
  end

  // counters observed at the pins
  int   oe_cnt = 0, low_cnt = 0;
  logic prev_sclk = 1'b1;
  logic [7:0] cap_word = 0;
  int   cap_n = 0;

  always @(negedge clk) begin
    cyc++;
    // external device drives the next bit of its word while a receive runs
    if (m_busy != 0 && m_tx == 0) sdat_in = slave_word[m_c / m_div];
    else sdat_in = 1'b1;
    #1;
    if (rst_n) begin
      chk("R4 sclk", int'(sclk), (m_busy == 0 || (m_c % m_div) >= m_div / 2) ? 1 : 0);
      chk("R5 oe", int'(sdat_oe), (m_busy != 0 && m_tx != 0) ? 1 : 0);
      chk("R5 sdat", int'(sdat), (m_busy != 0 && m_tx != 0) ? int'(m_txw[m_c / m_div]) : 1);
      chk("R2 ctrl", int'(ctrl_rd), int'({m_mode, m_fast, m_rxen, 2'b00, m_txd, m_rxd}));
      chk("R7 rx_data", int'(rx_data), int'(m_rxdata));
      if (sdat_oe) oe_cnt++;
      if (!sclk) low_cnt++;
      if (sdat_oe && sclk && !prev_sclk && cap_n < 8) begin
        cap_word[cap_n] = sdat;
        cap_n++;
      end
      prev_sclk = sclk;
    end
  end

  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic clr_counts();
    oe_cnt = 0; low_cnt = 0; cap_n = 0; cap_word = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  logic [7:0] held;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1 ctrl", int'(ctrl_rd), 0);
    chk("R1 rx_data", int'(rx_data), 0);
    chk("R1 pins", int'({sclk, sdat, sdat_oe}), 3'b110);

    // R2 register layout
    wr_ctrl(8'hFF); #2;
    chk("R2 readback ff", int'(ctrl_rd), 8'hF3);
    wr_ctrl(8'h00); #2;
    chk("R2 readback 00", int'(ctrl_rd), 8'h00);

    // slow transmit with a second write mid-word (R5, R4, R11)
    clr_counts();
    wr_data(8'hA5);
    repeat (20) @(negedge clk);
    wr_data(8'hFF);
    wait_idle();
    chk("R4 slow oe cycles", oe_cnt, 96);
    chk("R5 word out", int'(cap_word), 8'hA5);
    chk("R11 extra write ignored", cap_n, 8);
    chk("R6 tx_done", int'(ctrl_rd[1]), 1);
    chk("R12 idle pins", int'({sclk, sdat, sdat_oe}), 3'b110);

    // fast transmit, flag cleared by write (R4, R10)
    wr_ctrl(8'h20); #2;
    chk("R10 sw clears tx_done", int'(ctrl_rd[1]), 0);
    clr_counts();
    wr_data(8'h3C);
    wait_idle();
    chk("R4 fast oe cycles", oe_cnt, 32);
    chk("R5 fast word", int'(cap_word), 8'h3C);

    // hardware set and software clear on the same edge (R10)
    wr_data(8'h81);
    repeat (31) @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 8'h20;
    @(negedge clk); ctrl_we = 1'b0; #2;
    chk("R10 set wins", int'(ctrl_rd[1]), 1);

    // other mode: nothing starts (R3)
    wr_ctrl(8'h50);
    clr_counts();
    wr_data(8'h77);
    repeat (30) @(negedge clk);
    #2;
    chk("R3 no oe", oe_cnt, 0);
    chk("R3 no sclk", low_cnt, 0);

    // fast receive (R7)
    slave_word = 8'h5A;
    wr_ctrl(8'h30);
    wait_idle();
    chk("R7 rx word", int'(rx_data), 8'h5A);
    chk("R7 rx_done", int'(ctrl_rd[0]), 1);

    // lockout while flag set (R8)
    clr_counts();
    slave_word = 8'hC3;
    repeat (20) @(negedge clk);
    #2;
    chk("R8 no sclk while locked", low_cnt, 0);
    chk("R8 data held", int'(rx_data), 8'h5A);
    wr_ctrl(8'h30); #2;
    chk("R8 not yet started", int'(sclk), 1);
    @(negedge clk); #2;
    chk("R8 restart next cycle", int'(sclk), 0);
    wait_idle();
    chk("R7 second word", int'(rx_data), 8'hC3);

    // abort a slow receive (R9)
    wr_ctrl(8'h10);
    slave_word = 8'hEE;
    repeat (30) @(negedge clk);
    held = rx_data;
    wr_ctrl(8'h00);
    @(negedge clk); #2;
    chk("R9 sclk high", int'(sclk), 1);
    chk("R9 no flag", int'(ctrl_rd[0]), 0);
    chk("R9 data unchanged", int'(rx_data), int'(held));
    repeat (20) @(negedge clk);
    #2;
    chk("R12 idle after abort", int'({sclk, sdat, sdat_oe}), 3'b110);

    summary();
  end

endmodule